// File: doc/BRIEF.md
# Occupancy-Driven Fetch Thread Selector

This block decides, every cycle, which hardware thread of a simultaneous multithreaded front end may fetch. It tracks how many entries each thread holds in the shared issue queue and grants fetch to the eligible thread holding the fewest. Threads that hold few queue entries are draining quickly, so favouring them keeps the shared queue filled with useful work.

Each thread's count is kept in a counter. The counter rises by the number of entries dispatched into the queue for that thread and falls by the number issued out of it in the same cycle. A per-thread cap limits how much of the queue one thread may hold. The cap depends on how many threads are active. A single active thread may use the whole queue. When several threads are active, the queue is split evenly among them. Stalled threads are passed over, so other threads keep making progress. The grant is combinational from the registered counters, the round-robin pointer and the current inputs.

Top module: `fetch_thread_picker`

## Requirements
- R1: After reset every occupancy counter is 0 and the tie pointer selects thread 0 first. With all threads active, none stalled and no dispatch, the first grant is 4'b0001 for the default four threads.
- R2: When at least one thread is eligible, the grant goes to an eligible thread whose occupancy is the lowest among all eligible threads.
- R3: Among eligible threads with equal lowest occupancy, the search starts at the thread after the one granted most recently. The search wraps from the highest thread index to 0, and the first tied thread found wins. The pointer changes only in cycles that produce a grant.
- R4: A thread is eligible only when its bit in `thr_active` is 1, its bit in `thr_stall` is 0, and its occupancy is below its cap. A stalled or inactive thread is never granted, while other eligible threads are still granted.
- R5: The cap is `QDEPTH` when zero or one bit of `thr_active` is set. Otherwise it is `QDEPTH` divided by the number of set bits, rounded down.
- R6: Each cycle, a thread's counter becomes its old value plus its dispatch count minus its issue count. The result is clamped to the range 0 to `QDEPTH`.
- R7: When no thread is eligible, `fetch_grant` is all zeros.
- R8: `fetch_grant` always has at most one bit set. Bit k stands for thread k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active | input | NTHR | Bit k set: thread k is active |
| thr_stall | input | NTHR | Bit k set: thread k cannot fetch this cycle |
| disp_cnt | input | NTHR x CNTW | Entries dispatched into the queue for thread k this cycle |
| iss_cnt | input | NTHR x CNTW | Entries issued from the queue for thread k this cycle |
| fetch_grant | output | NTHR | One-hot fetch grant, or all zeros |

## Verification
The bound checker watches every cycle for the following properties:
- The grant is one-hot or zero.
- No stalled or inactive thread is granted.
- The granted thread is below its cap.
- The granted thread holds no more entries than any other eligible thread.
- The grant is zero when nothing is eligible.
- No counter exceeds the queue depth.

Only the bench scenarios can show the following:
- The round-robin order among tied threads.
- The exact counter arithmetic, including clamping at both ends.
- The cap change as threads join or leave.
The bench shows these by running a behavioural model alongside the design and comparing grants on every cycle.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
   function automatic int cap_for(input int depth, input int nact);
      return (nact <= 1) ? depth : depth / nact;
   endfunction
endpackage

// File: rtl/ftp_occ_counter.sv
module ftp_occ_counter #(
   parameter int QDEPTH = 16,
   parameter int CNTW   = 2,
   localparam int OW    = $clog2(QDEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CNTW-1:0] add_n,
   input  logic [CNTW-1:0] sub_n,
   output logic [OW-1:0]   occ
);
   localparam int SW = OW + CNTW + 1;
   logic [SW-1:0] sum;
   logic [OW-1:0] nxt;

   always_comb begin
      sum = SW'(occ) + SW'(add_n);
      if (sum < SW'(sub_n))
         nxt = '0;
      else if (sum - SW'(sub_n) > SW'(QDEPTH))
         nxt = OW'(QDEPTH);
      else
         nxt = OW'(sum - SW'(sub_n));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else        occ <= nxt;
   end
endmodule

// File: rtl/ftp_cap_calc.sv
module ftp_cap_calc #(
   parameter int NTHR   = 4,
   parameter int QDEPTH = 16,
   localparam int OW    = $clog2(QDEPTH + 1),
   localparam int PW    = $clog2(NTHR + 1)
) (
   input  logic [NTHR-1:0] active,
   output logic [OW-1:0]   cap
);
   logic [OW-1:0] cap_tab [NTHR+1];
   logic [PW-1:0] nact;

   for (genvar k = 0; k <= NTHR; k++) begin : g_tab
      assign cap_tab[k] = OW'(ftp_pkg::cap_for(QDEPTH, k));
   end

   always_comb begin
      nact = '0;
      for (int i = 0; i < NTHR; i++) nact = nact + PW'(active[i]);
   end

   assign cap = cap_tab[nact];
endmodule

// File: rtl/ftp_min_picker.sv
module ftp_min_picker #(
   parameter int NTHR   = 4,
   parameter int QDEPTH = 16,
   localparam int OW    = $clog2(QDEPTH + 1),
   localparam int TW    = $clog2(NTHR)
) (
   input  logic [NTHR-1:0]         elig,
   input  logic [NTHR-1:0][OW-1:0] occ,
   input  logic [TW-1:0]           last,
   output logic [NTHR-1:0]         grant,
   output logic [TW-1:0]           win
);
   always_comb begin
      logic          found;
      logic [OW-1:0] best;
      int            j;
      found = 1'b0;
      best  = '0;
      win   = last;
      for (int i = 0; i < NTHR; i++) begin
         j = int'(last) + 1 + i;
         if (j >= NTHR) j = j - NTHR;
         if (elig[j] && (!found || occ[j] < best)) begin
            found = 1'b1;
            best  = occ[j];
            win   = TW'(j);
         end
      end
      grant = '0;
      if (found) grant[win] = 1'b1;
   end
endmodule

// File: rtl/fetch_thread_picker.sv
module fetch_thread_picker #(
   parameter int NTHR   = 4,
   parameter int QDEPTH = 16,
   parameter int CNTW   = 2,
   localparam int OW    = $clog2(QDEPTH + 1),
   localparam int TW    = $clog2(NTHR)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NTHR-1:0]           thr_active,
   input  logic [NTHR-1:0]           thr_stall,
   input  logic [NTHR-1:0][CNTW-1:0] disp_cnt,
   input  logic [NTHR-1:0][CNTW-1:0] iss_cnt,
   output logic [NTHR-1:0]           fetch_grant
);
   if (NTHR < 2) begin : g_bad_nthr
      $error("fetch_thread_picker: NTHR must be at least 2");
   end
   if (QDEPTH < NTHR) begin : g_bad_depth
      $error("fetch_thread_picker: QDEPTH must be at least NTHR");
   end
   if (CNTW < 1) begin : g_bad_cntw
      $error("fetch_thread_picker: CNTW must be at least 1");
   end

   logic [NTHR-1:0][OW-1:0] occ_vec;
   logic [OW-1:0]           cap;
   logic [NTHR-1:0]         elig;
   logic [TW-1:0]           last_q, win;

   for (genvar k = 0; k < NTHR; k++) begin : g_thr
      ftp_occ_counter #(.QDEPTH(QDEPTH), .CNTW(CNTW)) cnt_i (
         .clk  (clk),
         .rst_n(rst_n),
         .add_n(disp_cnt[k]),
         .sub_n(iss_cnt[k]),
         .occ  (occ_vec[k])
      );
      assign elig[k] = thr_active[k] & ~thr_stall[k] & (occ_vec[k] < cap);
   end

   ftp_cap_calc #(.NTHR(NTHR), .QDEPTH(QDEPTH)) cap_i (
      .active(thr_active),
      .cap   (cap)
   );

   ftp_min_picker #(.NTHR(NTHR), .QDEPTH(QDEPTH)) pick_i (
      .elig (elig),
      .occ  (occ_vec),
      .last (last_q),
      .grant(fetch_grant),
      .win  (win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          last_q <= TW'(NTHR - 1);
      else if (|fetch_grant) last_q <= win;
   end
endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
   parameter int NTHR   = 4,
   parameter int QDEPTH = 16,
   localparam int OW    = $clog2(QDEPTH + 1)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NTHR-1:0]         thr_active,
   input logic [NTHR-1:0]         thr_stall,
   input logic [NTHR-1:0]         fetch_grant,
   input logic [NTHR-1:0][OW-1:0] occ_vec
);
   int   ck_cap;
   int   ck_gocc;
   logic ck_min_ok;

   always_comb begin
      int n;
      n = $countones(thr_active);
      ck_cap = (n > 1) ? (QDEPTH / n) : QDEPTH;
      ck_gocc = 0;
      for (int i = 0; i < NTHR; i++)
         if (fetch_grant[i]) ck_gocc = int'(occ_vec[i]);
      ck_min_ok = 1'b1;
      for (int i = 0; i < NTHR; i++)
         if (thr_active[i] && !thr_stall[i] && int'(occ_vec[i]) < ck_cap
             && int'(occ_vec[i]) < ck_gocc)
            ck_min_ok = 1'b0;
   end

   AST_ONEHOT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fetch_grant)); // R8
   AST_NO_BLOCKED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_grant & ~(thr_active & ~thr_stall)) == '0); // R4
   AST_FEWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|fetch_grant) |-> ck_min_ok); // R2
   AST_BELOW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (|fetch_grant) |-> (ck_gocc < ck_cap)); // R5
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((thr_active & ~thr_stall) == '0) |-> (fetch_grant == '0)); // R7

   for (genvar k = 0; k < NTHR; k++) begin : g_ovf
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         int'(occ_vec[k]) <= QDEPTH); // R6
   end
endmodule

bind fetch_thread_picker ftp_checker #(.NTHR(NTHR), .QDEPTH(QDEPTH)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .thr_active (thr_active),
   .thr_stall  (thr_stall),
   .fetch_grant(fetch_grant),
   .occ_vec    (occ_vec)
);

// File: tb/fetch_thread_picker_tb_top.sv
module fetch_thread_picker_tb_top;
   localparam int N = 4;
   localparam int D = 16;
   localparam int W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] act = '0, stl = '0;
   logic [N-1:0][W-1:0] dsp = '0, iss = '0;
   logic [N-1:0] gnt;

   int total = 0, bad = 0;
   int m_occ [N];
   int m_last = N - 1;
   bit done = 0;

   always #2 clk = ~clk;

   fetch_thread_picker #(.NTHR(N), .QDEPTH(D), .CNTW(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .thr_active(act), .thr_stall(stl),
      .disp_cnt(dsp), .iss_cnt(iss), .fetch_grant(gnt));

   function automatic int model_pick();
      int n, cap, best;
      n = 0;
      foreach (act[i]) if (act[i]) n++;
      cap = (n <= 1) ? D : D / n;
      best = -1;
      for (int s = 1; s <= N; s++) begin
         int j;
         j = (m_last + s) % N;
         if (act[j] && !stl[j] && m_occ[j] < cap)
            if (best < 0 || m_occ[j] < m_occ[best]) best = j;
      end
      return best;
   endfunction

   task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: grant=%b expected=%b at %0t", req, got, exp, $time);
      end
   endtask

   // drive inputs for one cycle, compare grant with model, then advance model
   task automatic step(input string req);
      int b;
      logic [N-1:0] e;
      #1;
      b = model_pick();
      e = '0;
      if (b >= 0) e[b] = 1'b1;
      check(req, gnt, e);
      for (int k = 0; k < N; k++) begin
         int v;
         v = m_occ[k] + int'(dsp[k]) - int'(iss[k]);
         m_occ[k] = (v < 0) ? 0 : ((v > D) ? D : v);
      end
      if (b >= 0) m_last = b;
      @(negedge clk);
   endtask

   initial begin : wdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: cycles expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      foreach (m_occ[i]) m_occ[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, thread 0 first
      act = '1; stl = '0; dsp = '0; iss = '0;
      #1 check("R1", gnt, 4'b0001);
      #0;
      step("R1");
      // R3: equal counts rotate
      for (int c = 0; c < 8; c++) step("R3");
      // R5/R6: lone thread fills full queue, overflow clamps
      act = 4'b0001;
      for (int c = 0; c < 10; c++) begin dsp[0] = 2'd2; step("R5"); end
      dsp = '0;
      #1 check("R5", gnt, 4'b0000);
      #0;
      iss[0] = 2'd1; step("R6");
      iss[0] = 2'd0; step("R6");
      for (int c = 0; c < 10; c++) begin iss[0] = 2'd2; step("R6"); end
      iss = '0;
      // R4/R7: two active, thread 1 stalled, thread 0 hits half-queue cap
      act = 4'b0011; stl = 4'b0010;
      for (int c = 0; c < 6; c++) begin dsp[0] = 2'd2; step("R4"); end
      dsp = '0;
      #1 check("R7", gnt, 4'b0000);
      #0;
      stl = '0; step("R4");
      // R2: uneven loads, lowest wins
      act = '1;
      for (int c = 0; c < 12; c++) begin
         foreach (dsp[k]) dsp[k] = W'(k % 3);
         step("R2");
      end
      dsp = '0;
      // R8 and general: random traffic
      for (int c = 0; c < 4000; c++) begin
         act = N'($urandom);
         if ($urandom_range(0, 7) == 0) act = '0;
         stl = N'($urandom) & N'($urandom);
         foreach (dsp[k]) begin
            dsp[k] = W'($urandom);
            iss[k] = W'($urandom);
         end
         step("R8");
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule